// File: doc/BRIEF.md
# Legacy Processor Presence Map

This block keeps a map of which processors are present, one bit per possible processor, where the bit position is the processor's identifier. Software reads the map one byte at a time through a small register window. Writes never change the map. When a hot-add request arrives for an identifier in range, the matching bit is set, and a hotplug event status bit is raised. The interrupt output is that status bit gated by an enable bit. Software clears the status bit by writing a one to it. Processors are never removed: once set, a bit stays set until power-on reset.

The first four bytes of the window also detect the switch to the newer hotplug interface. When all four bytes have been written with zero, the block sets its mode output. From then on the map is no longer decoded for reads, and hot-add requests no longer raise the legacy event. Only the power-on reset returns the block to legacy mode.

Top module: `hp_legacy_cpumap`

## Requirements
- R1: After reset, every map bit except bit 0 is clear, `modern_mode` is 0, `evt_sts` is 0x00, `sci` is 0 and `reg_rdata` is 0x00.
- R2: A read (`reg_rd_en` high at a clock edge) of byte address k below MAP_BYTES loads `reg_rdata` at that edge with map bits 8k to 8k+7, with bit i of the byte holding processor 8k+i. A hot-add in the same cycle is not visible. `reg_rdata` holds its value when no read takes place.
- R3: Bit 0 of the map (boot processor) always reads as 1 in legacy mode.
- R4: A hot-add (`hotadd_valid` high) with `hotadd_id` below NUM_CPUS sets that bit at the next edge. An identifier of NUM_CPUS or above changes no bit and raises no event.
- R5: Writes to the register window never change any map bit, and no bit ever goes from 1 to 0 except through reset.
- R6: In legacy mode, an in-range hot-add sets bit 2 of `evt_sts` (all other bits read 0). A status write (`evt_wr_en` with `evt_sel`=0) that has bit 2 at 1 clears it, and one that has bit 2 at 0 leaves it unchanged. A hot-add in the same cycle as a clear wins.
- R7: An enable write (`evt_wr_en` with `evt_sel`=1) stores bit 2 of `evt_wdata`. `sci` is high exactly when status bit 2 and enable bit 2 are both set.
- R8: In legacy mode, each write to byte address 0 to 3 records whether the written value was zero, replacing that byte's earlier record. `modern_mode` rises at the edge of the write that leaves all four records at zero. A nonzero write cancels only its own byte's record.
- R9: Once `modern_mode` is 1, it stays 1 until reset. Reads return 0x00, and hot-adds no longer set the event status.
- R10: In legacy mode, reads of byte addresses from MAP_BYTES up to the top of the window return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| reg_rd_en | input | 1 | Byte read strobe |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_addr | input | ADDR_W | Byte address inside the window |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, registered |
| hotadd_valid | input | 1 | Hot-add request |
| hotadd_id | input | ID_W | Identifier of the processor being added |
| evt_wr_en | input | 1 | Event register write strobe |
| evt_sel | input | 1 | 0 selects status (write one to clear), 1 selects enable |
| evt_wdata | input | 8 | Event register write data; bit 2 is used |
| evt_sts | output | 8 | Event status; only bit 2 can be set |
| sci | output | 1 | System interrupt request |
| modern_mode | output | 1 | 1 once the window has been handed over |

## Verification
The assertions assume that the inputs are steady at each rising edge, and that a read and a write to the window in the same cycle are both allowed. They also assume that `hotadd_id` may take any value of its width, including values at or above NUM_CPUS. The stimulus changes inputs only on falling edges. It draws identifiers over the full ID_W range, so that out-of-range requests occur. Zero writes to bytes 0 to 3 come often enough that the switch happens many times, and occasional resets bring the block back to legacy mode.

// File: rtl/hp_cpumap_pkg.sv
package hp_cpumap_pkg;

  localparam int unsigned HP_EVT_BIT   = 2;
  localparam int unsigned SWITCH_BYTES = 4;

  function automatic int unsigned map_bytes(input int unsigned ncpu);
    return (ncpu + 7) / 8;
  endfunction

  function automatic logic id_in_range(input int unsigned id, input int unsigned ncpu);
    return id < ncpu;
  endfunction

  function automatic logic [7:0] evt_byte(input logic flag);
    logic [7:0] b;
    b = '0;
    b[HP_EVT_BIT] = flag;
    return b;
  endfunction

endpackage

// File: rtl/hp_presence_map.sv
module hp_presence_map
  import hp_cpumap_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 48,
  parameter int unsigned ID_W     = 6,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_valid,
  input  logic [ID_W-1:0]     add_id,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_block,
  output logic [7:0]          rdata,
  output logic [NUM_CPUS-1:0] present
);

  localparam int unsigned MAP_BYTES = map_bytes(NUM_CPUS);

  logic [NUM_CPUS-1:1]    added_q;
  logic [MAP_BYTES*8-1:0] padded;
  logic [7:0]             sel_byte;

  assign present = {added_q, 1'b1};

  for (genvar i = 1; i < NUM_CPUS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        added_q[i] <= 1'b0;
      end else if (add_valid && (int'(add_id) == i)) begin
        added_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    padded = '0;
    padded[NUM_CPUS-1:0] = present;
  end

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < MAP_BYTES; k++) begin
      if (int'(rd_addr) == k) sel_byte = padded[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_block ? 8'h00 : sel_byte;
    end
  end

endmodule

// File: rtl/hp_mode_switch.sv
module hp_mode_switch
  import hp_cpumap_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              switch_fire,
  output logic              modern
);

  logic [SWITCH_BYTES-1:0] zero_rec_q;
  logic [SWITCH_BYTES-1:0] this_byte;
  logic                    hit;

  assign hit = wr_en && !modern && (int'(wr_addr) < SWITCH_BYTES);

  always_comb begin
    this_byte = '0;
    for (int k = 0; k < SWITCH_BYTES; k++) begin
      if (int'(wr_addr) == k) this_byte[k] = 1'b1;
    end
  end

  assign switch_fire = hit && (wr_data == 8'h00) && ((zero_rec_q | this_byte) == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_rec_q <= '0;
    end else if (hit) begin
      zero_rec_q <= (wr_data == 8'h00) ? (zero_rec_q | this_byte) : (zero_rec_q & ~this_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modern <= 1'b0;
    end else if (switch_fire) begin
      modern <= 1'b1;
    end
  end

endmodule

// File: rtl/hp_event_reg.sv
module hp_event_reg
  import hp_cpumap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_evt,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sts,
  output logic       irq
);

  logic sts_q;
  logic en_q;
  logic clr;

  assign clr = wr_en && !wr_sel && wr_data[HP_EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else if (set_evt) begin
      sts_q <= 1'b1;
    end else if (clr) begin
      sts_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_en && wr_sel) begin
      en_q <= wr_data[HP_EVT_BIT];
    end
  end

  assign sts = evt_byte(sts_q);
  assign irq = sts_q && en_q;

endmodule

// File: rtl/hp_legacy_cpumap.sv
module hp_legacy_cpumap
  import hp_cpumap_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 48,
  parameter int unsigned ID_W     = 6,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              hotadd_valid,
  input  logic [ID_W-1:0]   hotadd_id,
  input  logic              evt_wr_en,
  input  logic              evt_sel,
  input  logic [7:0]        evt_wdata,
  output logic [7:0]        evt_sts,
  output logic              sci,
  output logic              modern_mode
);

  logic                add_ok;
  logic                hot_evt;
  logic                switch_fire;
  logic [NUM_CPUS-1:0] present_vec;

  assign add_ok  = hotadd_valid && id_in_range(int'(hotadd_id), NUM_CPUS);
  assign hot_evt = add_ok && !modern_mode;

  hp_presence_map #(
    .NUM_CPUS(NUM_CPUS),
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W)
  ) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_valid(add_ok),
    .add_id   (hotadd_id),
    .rd_en    (reg_rd_en),
    .rd_addr  (reg_addr),
    .rd_block (modern_mode),
    .rdata    (reg_rdata),
    .present  (present_vec)
  );

  hp_mode_switch #(
    .ADDR_W(ADDR_W)
  ) mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .switch_fire(switch_fire),
    .modern     (modern_mode)
  );

  hp_event_reg evt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(hot_evt),
    .wr_en  (evt_wr_en),
    .wr_sel (evt_sel),
    .wr_data(evt_wdata),
    .sts    (evt_sts),
    .irq    (sci)
  );

endmodule

// File: rtl/hp_legacy_cpumap_chk.sv
module hp_legacy_cpumap_chk #(
  parameter int unsigned NUM_CPUS = 48,
  parameter int unsigned ID_W     = 6,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_rd_en,
  input logic                reg_wr_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          reg_wdata,
  input logic [7:0]          reg_rdata,
  input logic                hotadd_valid,
  input logic [ID_W-1:0]     hotadd_id,
  input logic [7:0]          evt_sts,
  input logic                modern_mode,
  input logic [NUM_CPUS-1:0] present_vec
);

  AST_BOOT_BIT_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == '0 && !modern_mode) |=> reg_rdata[0]); // R3

  AST_NO_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((present_vec & $past(present_vec)) == $past(present_vec))); // R5

  AST_HOTADD_RAISES_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (hotadd_valid && int'(hotadd_id) < NUM_CPUS && !modern_mode) |=> evt_sts[2]); // R6

  AST_SWITCH_NEEDS_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modern_mode) |-> $past(reg_wr_en && reg_wdata == 8'h00 && int'(reg_addr) < 4)); // R8

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    modern_mode |=> modern_mode); // R9

  AST_MODERN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && modern_mode) |=> (reg_rdata == 8'h00)); // R9

endmodule

bind hp_legacy_cpumap hp_legacy_cpumap_chk #(
  .NUM_CPUS(NUM_CPUS),
  .ID_W    (ID_W),
  .ADDR_W  (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd_en   (reg_rd_en),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .hotadd_valid(hotadd_valid),
  .hotadd_id   (hotadd_id),
  .evt_sts     (evt_sts),
  .modern_mode (modern_mode),
  .present_vec (present_vec)
);

// File: tb/hp_legacy_cpumap_tb_top.sv
module hp_legacy_cpumap_tb_top;

  localparam int CLK_P    = 10;
  localparam int NCPU     = 48;
  localparam int IDW      = 6;
  localparam int AW       = 5;
  localparam int NBYTES   = (NCPU + 7) / 8;
  localparam int WDOG_MAX = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_rd_en = 1'b0, reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          hotadd_valid = 1'b0;
  logic [IDW-1:0] hotadd_id = '0;
  logic          evt_wr_en = 1'b0, evt_sel = 1'b0;
  logic [7:0]    evt_wdata = '0;
  logic [7:0]    evt_sts;
  logic          sci, modern_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hp_legacy_cpumap #(.NUM_CPUS(NCPU), .ID_W(IDW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hotadd_valid(hotadd_valid), .hotadd_id(hotadd_id),
    .evt_wr_en(evt_wr_en), .evt_sel(evt_sel), .evt_wdata(evt_wdata),
    .evt_sts(evt_sts), .sci(sci), .modern_mode(modern_mode)
  );

  // behavioural reference model
  bit m_pres[NCPU];
  bit m_zero[4];
  bit m_mode, m_sts, m_en;
  int m_rdata;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    bit old_mode;
    bit setev;
    int b;
    cycles++;
    if (!rst_n) begin
      foreach (m_pres[i]) m_pres[i] = (i == 0);
      foreach (m_zero[i]) m_zero[i] = 0;
      m_mode = 0; m_sts = 0; m_en = 0; m_rdata = 0;
    end else begin
      old_mode = m_mode;
      if (reg_rd_en) begin
        if (old_mode || int'(reg_addr) >= NBYTES) m_rdata = 0;
        else begin
          b = 0;
          for (int j = 0; j < 8; j++)
            if (int'(reg_addr) * 8 + j < NCPU && m_pres[int'(reg_addr) * 8 + j]) b += (1 << j);
          m_rdata = b;
        end
      end
      setev = hotadd_valid && int'(hotadd_id) < NCPU && !old_mode;
      if (hotadd_valid && int'(hotadd_id) < NCPU) m_pres[int'(hotadd_id)] = 1;
      if (setev) m_sts = 1;
      else if (evt_wr_en && !evt_sel && evt_wdata[2]) m_sts = 0;
      if (evt_wr_en && evt_sel) m_en = evt_wdata[2];
      if (reg_wr_en && !old_mode && int'(reg_addr) < 4) begin
        m_zero[int'(reg_addr)] = (reg_wdata == 8'h00);
        if (m_zero[0] && m_zero[1] && m_zero[2] && m_zero[3]) m_mode = 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    check("R2 rdata", int'(reg_rdata), m_rdata);
    check("R6 evt_sts", int'(evt_sts), m_sts ? 4 : 0);
    check("R7 sci", int'(sci), int'(m_sts && m_en));
    check("R9 mode", int'(modern_mode), int'(m_mode));
  end

  always @(posedge clk) begin
    if (cycles > WDOG_MAX) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WDOG_MAX);
      finish_run();
    end
  end

  task automatic idle();
    reg_rd_en = 0; reg_wr_en = 0; hotadd_valid = 0; evt_wr_en = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input int a);
    reg_rd_en = 1; reg_addr = AW'(a);
    step();
  endtask

  task automatic wr(input int a, input int d);
    reg_wr_en = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    step();
  endtask

  task automatic add(input int id);
    hotadd_valid = 1; hotadd_id = IDW'(id);
    step();
  endtask

  task automatic evw(input bit s, input int d);
    evt_wr_en = 1; evt_sel = s; evt_wdata = 8'(d);
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 evt_sts", int'(evt_sts), 0);
    check("R1 sci", int'(sci), 0);
    check("R1 mode", int'(modern_mode), 0);
    rd(1); check("R1 byte1", int'(reg_rdata), 0);
    rd(0); check("R3 boot bit", int'(reg_rdata), 8'h01);

    add(5); check("R6 sts set", int'(evt_sts), 8'h04);
    add(9); add(47);
    rd(0); check("R2 byte0", int'(reg_rdata), 8'h21);
    rd(1); check("R2 byte1", int'(reg_rdata), 8'h02);
    rd(5); check("R2 byte5", int'(reg_rdata), 8'h80);

    evw(0, 8'h04); check("R6 cleared", int'(evt_sts), 0);
    add(50); check("R4 out of range no event", int'(evt_sts), 0);
    rd(6); check("R10 byte6", int'(reg_rdata), 0);
    rd(20); check("R10 byte20", int'(reg_rdata), 0);

    wr(1, 8'h00); wr(2, 8'hFF); wr(5, 8'h00);
    rd(1); check("R5 write ignored", int'(reg_rdata), 8'h02);
    rd(5); check("R5 write ignored b5", int'(reg_rdata), 8'h80);

    evw(1, 8'h04);
    add(9); check("R7 sci raised", int'(sci), 1);
    evw(0, 8'hFB); check("R6 zero bit no clear", int'(evt_sts), 8'h04);
    evw(0, 8'h04); check("R7 sci dropped", int'(sci), 0);
    hotadd_valid = 1; hotadd_id = 6'd3; evt_wr_en = 1; evt_sel = 0; evt_wdata = 8'h04;
    step(); check("R6 set wins", int'(evt_sts), 8'h04);
    evw(0, 8'h04);

    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 8'h10);
    check("R8 nonzero byte no switch", int'(modern_mode), 0);
    wr(0, 8'h05); wr(3, 0);
    check("R8 cancelled byte0", int'(modern_mode), 0);
    wr(0, 0);
    check("R8 switch", int'(modern_mode), 1);

    rd(0); check("R9 read zero", int'(reg_rdata), 0);
    add(10); check("R9 no event", int'(evt_sts), 0);
    wr(0, 8'hAA); check("R9 sticky", int'(modern_mode), 1);

    do_reset();
    check("R1 mode after reset", int'(modern_mode), 0);
    rd(1); check("R1 map cleared", int'(reg_rdata), 0);
    rd(0); check("R3 boot after reset", int'(reg_rdata), 8'h01);

    for (int n = 0; n < 4000; n++) begin
      reg_rd_en    = ($urandom % 2) == 0;
      reg_wr_en    = ($urandom % 3) == 0;
      reg_addr     = AW'(($urandom % 4 == 0) ? $urandom : $urandom % 8);
      reg_wdata    = ($urandom % 2) ? 8'h00 : 8'($urandom);
      hotadd_valid = ($urandom % 4) == 0;
      hotadd_id    = IDW'($urandom);
      evt_wr_en    = ($urandom % 5) == 0;
      evt_sel      = 1'($urandom);
      evt_wdata    = 8'($urandom);
      rst_n        = ($urandom % 400) != 0;
      @(negedge clk);
    end
    idle(); rst_n = 1;
    step();
    finish_run();
  end

endmodule